// File: doc/BRIEF.md
# Slow-Domain Register Write Synchronizer

This block carries register writes from a fast bus clock into a slow peripheral clock. The bus side holds a shadow copy of every register and a busy flag for each one. A write fills the shadow and raises that register's busy flag. The busy flag drops only after the slow-domain copy holds the new value. The peripheral logic reads the slow-domain copies directly.

A single freeze input lets software prepare several registers before any of them reaches the slow domain. While freeze is high, new writes wait in their shadows and their busy flags stay high. When freeze goes low, all waiting registers move across as one batch. They update on the same slow clock edge, so the peripheral never sees a half-applied set of values.

The crossing works as follows. One toggle request travels from the fast domain into the slow domain, and one toggle acknowledge travels back. Each direction passes through a two-flop synchronizer. The launch mask and the shadows stay stable for the whole round trip. A write that hits a register whose busy flag is still high is discarded, and it raises a sticky error flag.

Top module: `wsync_top`

## Requirements
- R1: An accepted write to register i sets busy[i] on the next bus clock edge. busy[i] stays high until slow_regs already holds the written value, and then returns low without any further input.
- R2: With freeze low, no transfer in flight, and the bus clock at least 4 times the slow clock, a write's value appears in slow_regs on the third rising slow_clk edge after the bus edge that captured the write. slow_regs never changes without a request arriving.
- R3: While freeze is high, values written after it rose do not reach slow_regs, and their busy flags stay high.
- R4: When freeze falls, every register still waiting updates in slow_regs on one common slow_clk edge.
- R5: A write to a register whose busy flag is high is discarded. The value that eventually reaches slow_regs is the first one written.
- R6: Such a discarded write sets wr_err on the next bus clock edge. wr_err stays high until bus_rst.
- R7: After reset, busy is all zero, wr_err is 0 and slow_regs is all zero.
- R8: Address value i selects register i. Its copy occupies slow_regs[i*DATA_W +: DATA_W]. A write to one register leaves the copies of all other registers unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| bus_clk | input | 1 | Fast bus clock |
| bus_rst | input | 1 | Synchronous active-high reset, bus domain |
| wr_en | input | 1 | Write strobe, one bus cycle per write |
| wr_addr | input | ADDR_W | Register index of the write |
| wr_data | input | DATA_W | Write value |
| freeze | input | 1 | High: hold pending transfers; falling: release them as one batch |
| busy | output | NUM_REGS | Per-register transfer-in-progress flag |
| wr_err | output | 1 | Sticky flag for a write discarded because its register was busy |
| slow_clk | input | 1 | Slow peripheral clock |
| slow_rst | input | 1 | Synchronous active-high reset, slow domain |
| slow_regs | output | NUM_REGS*DATA_W | Slow-domain register copies, register i in slice i |

## Verification
The bench builds the block with four 16-bit registers. The bus clock is 200 MHz and the slow clock runs eight times slower. Four registers are enough to cover every address decode. They also give a freeze batch wide enough that a partial update would show as some slices matching and others not. The slow clock's edges line up with bus edges, so the three-edge latency can be counted exactly. The ratio also leaves room for a second write to land while the first is still in flight.

// File: rtl/wsync_pkg.sv
package wsync_pkg;
  // Index width for a register count, never below one bit.
  function automatic int idx_bits(input int n);
    int b;
    b = 1;
    while ((1 << b) < n) b++;
    return b;
  endfunction
endpackage

// File: rtl/wsync_sync2.sv
module wsync_sync2 #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk) begin
    if (rst) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/wsync_bus_side.sv
module wsync_bus_side #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       freeze,
  input  logic                       ack_sync,
  output logic [NUM_REGS-1:0]        busy,
  output logic                       err,
  output logic [NUM_REGS*DATA_W-1:0] shadow_flat,
  output logic [NUM_REGS-1:0]        launch_mask,
  output logic                       req_tgl,
  output logic                       in_flight
);
  logic [NUM_REGS-1:0] hit;
  logic [NUM_REGS-1:0] accept;
  logic [NUM_REGS-1:0] clr;
  logic                collide;
  logic                ack_seen;
  logic                ack_edge;
  logic                launch;
  logic [DATA_W-1:0]   shadow_q [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    assign hit[i] = wr_en && (wr_addr == ADDR_W'(i));
    assign shadow_flat[i*DATA_W +: DATA_W] = shadow_q[i];
  end

  always_comb begin
    accept   = hit & ~busy;
    collide  = |(hit & busy);
    ack_edge = ack_sync ^ ack_seen;
    clr      = ack_edge ? launch_mask : '0;
    launch   = !freeze && !in_flight && (|busy);
  end

  // Shadow storage: no reset, one write port, RAM-friendly.
  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_REGS; i++) begin
      if (accept[i]) shadow_q[i] <= wr_data;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy        <= '0;
      err         <= 1'b0;
      launch_mask <= '0;
      req_tgl     <= 1'b0;
      in_flight   <= 1'b0;
      ack_seen    <= 1'b0;
    end else begin
      ack_seen <= ack_sync;
      err      <= err | collide;
      busy     <= (busy & ~clr) | accept;
      if (launch) begin
        launch_mask <= busy;
        req_tgl     <= ~req_tgl;
        in_flight   <= 1'b1;
      end else if (ack_edge) begin
        launch_mask <= '0;
        in_flight   <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/wsync_periph_side.sv
module wsync_periph_side #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       req_sync,
  input  logic [NUM_REGS-1:0]        launch_mask,
  input  logic [NUM_REGS*DATA_W-1:0] shadow_flat,
  output logic                       ack_tgl,
  output logic [NUM_REGS*DATA_W-1:0] copies_flat
);
  logic              upd;
  logic [DATA_W-1:0] copy_q [NUM_REGS];

  assign upd = req_sync ^ ack_tgl;

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_out
    assign copies_flat[i*DATA_W +: DATA_W] = copy_q[i];
  end

  // The mask and shadows are held still by the bus side for the whole
  // round trip, so sampling them here on the request edge is safe.
  always_ff @(posedge clk) begin
    if (rst) begin
      ack_tgl <= 1'b0;
      for (int i = 0; i < NUM_REGS; i++) copy_q[i] <= '0;
    end else begin
      ack_tgl <= req_sync;
      for (int i = 0; i < NUM_REGS; i++) begin
        if (upd && launch_mask[i]) copy_q[i] <= shadow_flat[i*DATA_W +: DATA_W];
      end
    end
  end
endmodule

// File: rtl/wsync_top.sv
module wsync_top #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = wsync_pkg::idx_bits(NUM_REGS)
) (
  input  logic                       bus_clk,
  input  logic                       bus_rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic                       freeze,
  output logic [NUM_REGS-1:0]        busy,
  output logic                       wr_err,
  input  logic                       slow_clk,
  input  logic                       slow_rst,
  output logic [NUM_REGS*DATA_W-1:0] slow_regs
);
  logic [NUM_REGS*DATA_W-1:0] shadow_flat;
  logic [NUM_REGS-1:0]        launch_mask;
  logic                       req_tgl;
  logic                       req_sync;
  logic                       ack_tgl;
  logic                       ack_sync;
  logic                       in_flight;

  wsync_bus_side #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bus (
    .clk(bus_clk), .rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .freeze(freeze), .ack_sync(ack_sync), .busy(busy), .err(wr_err),
    .shadow_flat(shadow_flat), .launch_mask(launch_mask), .req_tgl(req_tgl),
    .in_flight(in_flight)
  );

  wsync_sync2 #(.W(1)) u_req_sync (
    .clk(slow_clk), .rst(slow_rst), .d(req_tgl), .q(req_sync)
  );

  wsync_sync2 #(.W(1)) u_ack_sync (
    .clk(bus_clk), .rst(bus_rst), .d(ack_tgl), .q(ack_sync)
  );

  wsync_periph_side #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_periph (
    .clk(slow_clk), .rst(slow_rst), .req_sync(req_sync), .launch_mask(launch_mask),
    .shadow_flat(shadow_flat), .ack_tgl(ack_tgl), .copies_flat(slow_regs)
  );
endmodule

// File: rtl/wsync_checker.sv
module wsync_checker #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 2
) (
  input logic                       bus_clk,
  input logic                       bus_rst,
  input logic                       slow_clk,
  input logic                       slow_rst,
  input logic                       wr_en,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic                       freeze,
  input logic [NUM_REGS-1:0]        busy,
  input logic                       wr_err,
  input logic                       req_tgl,
  input logic                       in_flight,
  input logic                       ack_sync,
  input logic                       req_sync,
  input logic                       ack_tgl,
  input logic [NUM_REGS*DATA_W-1:0] slow_regs
);
  // R1: an accepted write raises its busy flag
  a_r1_busy_sets: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (wr_en && !busy[wr_addr]) |=> busy[$past(wr_addr)]);

  // R1: busy only drops after an acknowledge came back
  a_r1_busy_clears_on_ack: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (|($past(busy) & ~busy)) |-> ($past(ack_sync) != $past(ack_sync, 2)));

  // R2: slow copies move only when a request arrives
  a_r2_no_spurious_update: assert property (@(posedge slow_clk) disable iff (slow_rst)
    (req_sync == ack_tgl) |=> $stable(slow_regs));

  // R3: no new request is launched while frozen
  a_r3_frozen_no_launch: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (freeze && !in_flight) |=> $stable(req_tgl));

  // R6: a write to a busy register raises the error flag
  a_r6_collision_flags: assert property (@(posedge bus_clk) disable iff (bus_rst)
    (wr_en && busy[wr_addr]) |=> wr_err);

  // R6: the error flag is sticky
  a_r6_err_sticky: assert property (@(posedge bus_clk) disable iff (bus_rst)
    wr_err |=> wr_err);
endmodule

bind wsync_top wsync_checker #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .ADDR_W(ADDR_W)) i_chk (
  .bus_clk(bus_clk), .bus_rst(bus_rst), .slow_clk(slow_clk), .slow_rst(slow_rst),
  .wr_en(wr_en), .wr_addr(wr_addr), .freeze(freeze), .busy(busy), .wr_err(wr_err),
  .req_tgl(req_tgl), .in_flight(in_flight), .ack_sync(ack_sync), .req_sync(req_sync),
  .ack_tgl(ack_tgl), .slow_regs(slow_regs)
);

// File: tb/test_wsync_top.sv
`timescale 1ns/1ps
module test_wsync_top;
  localparam int NR = 4;
  localparam int DW = 16;
  localparam int AW = 2;

  logic bus_clk = 1'b0, slow_clk = 1'b0;
  logic bus_rst = 1'b1, slow_rst = 1'b1;
  logic wr_en = 1'b0, freeze = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [NR-1:0] busy;
  logic wr_err;
  logic [NR*DW-1:0] slow_regs;

  int n_chk = 0, n_bad = 0;
  logic [DW-1:0] model [NR];

  always #2.5 bus_clk = ~bus_clk;   // 200 MHz
  always #20  slow_clk = ~slow_clk; // 8x slower

  wsync_top #(.NUM_REGS(NR), .DATA_W(DW)) i_wsync_top (
    .bus_clk(bus_clk), .bus_rst(bus_rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .freeze(freeze), .busy(busy), .wr_err(wr_err),
    .slow_clk(slow_clk), .slow_rst(slow_rst), .slow_regs(slow_regs)
  );

  // {addr, data}
  localparam logic [AW+DW-1:0] VECS [8] = '{
    {2'd0, 16'h1234}, {2'd1, 16'hFFFF}, {2'd2, 16'h0000}, {2'd3, 16'hA5A5},
    {2'd0, 16'h8001}, {2'd2, 16'h7FFE}, {2'd1, 16'h0001}, {2'd3, 16'h5A5A}
  };

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_write(input int a, input logic [DW-1:0] d);
    @(negedge bus_clk);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge bus_clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 2000; k++) begin
      if (busy == '0) break;
      @(negedge bus_clk);
    end
  endtask

  function automatic logic [NR*DW-1:0] model_flat();
    logic [NR*DW-1:0] f;
    for (int i = 0; i < NR; i++) f[i*DW +: DW] = model[i];
    return f;
  endfunction

  initial begin
    #100000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NR; i++) model[i] = '0;
    repeat (4) @(posedge slow_clk);
    @(negedge bus_clk);
    bus_rst = 1'b0; slow_rst = 1'b0;
    @(negedge bus_clk);

    // R7 reset state
    chk(busy == '0, "R7 busy", 64'(busy), 0);
    chk(wr_err == 1'b0, "R7 err", 64'(wr_err), 0);
    chk(slow_regs == '0, "R7 slow_regs", 64'(slow_regs), 0);

    // Table walk: R1 and R8
    for (int v = 0; v < 8; v++) begin
      int a;
      logic [DW-1:0] d;
      a = int'(VECS[v][AW+DW-1:DW]);
      d = VECS[v][DW-1:0];
      do_write(a, d);
      chk(busy[a] == 1'b1, "R1 busy set", 64'(busy), 64'(1 << a));
      wait_idle();
      model[a] = d;
      chk(busy == '0, "R1 busy cleared", 64'(busy), 0);
      chk(slow_regs == model_flat(), "R1/R8 copy on busy clear", 64'(slow_regs), 64'(model_flat()));
    end

    // R2 exact latency: three slow edges
    begin
      int n;
      n = 0;
      @(posedge slow_clk);
      do_write(2, 16'hC3C3);
      for (int k = 0; k < 8; k++) begin
        @(posedge slow_clk); #1;
        n++;
        if (slow_regs[2*DW +: DW] == 16'hC3C3) break;
      end
      chk(n == 3, "R2 latency in slow edges", 64'(n), 3);
      model[2] = 16'hC3C3;
      wait_idle();
    end

    // R3 freeze holds, R4 batch release
    begin
      bit partial;
      int seen;
      @(negedge bus_clk); freeze = 1'b1;
      for (int i = 0; i < NR; i++) do_write(i, 16'h1100 + 16'(i));
      repeat (10) @(posedge slow_clk);
      #1;
      chk(slow_regs == model_flat(), "R3 frozen copies unchanged", 64'(slow_regs), 64'(model_flat()));
      chk(busy == '1, "R3 busy held", 64'(busy), 64'hF);
      @(negedge bus_clk); freeze = 1'b0;
      partial = 1'b0;
      for (int k = 0; k < 10; k++) begin
        @(posedge slow_clk); #1;
        seen = 0;
        for (int i = 0; i < NR; i++)
          if (slow_regs[i*DW +: DW] == 16'h1100 + 16'(i)) seen++;
        if (seen != 0 && seen != NR) partial = 1'b1;
      end
      chk(!partial, "R4 no partial batch", 64'(partial), 0);
      for (int i = 0; i < NR; i++) model[i] = 16'h1100 + 16'(i);
      wait_idle();
      chk(slow_regs == model_flat(), "R4 batch applied", 64'(slow_regs), 64'(model_flat()));
      chk(busy == '0, "R4 busy cleared", 64'(busy), 0);
    end

    // R5/R6 collision
    chk(wr_err == 1'b0, "R6 err clear before collision", 64'(wr_err), 0);
    do_write(1, 16'hBEEF);
    do_write(1, 16'hDEAD);
    chk(wr_err == 1'b1, "R6 err raised", 64'(wr_err), 1);
    wait_idle();
    repeat (20) @(negedge bus_clk);
    model[1] = 16'hBEEF;
    chk(slow_regs[DW +: DW] == 16'hBEEF, "R5 second write dropped", 64'(slow_regs[DW +: DW]), 64'hBEEF);
    chk(slow_regs == model_flat(), "R8 others untouched", 64'(slow_regs), 64'(model_flat()));
    chk(wr_err == 1'b1, "R6 err sticky", 64'(wr_err), 1);

    // R7 reset again
    @(negedge bus_clk); bus_rst = 1'b1; slow_rst = 1'b1;
    repeat (2) @(posedge slow_clk);
    @(negedge bus_clk); bus_rst = 1'b0; slow_rst = 1'b0;
    #1;
    chk(wr_err == 1'b0, "R7 err after reset", 64'(wr_err), 0);
    chk(slow_regs == '0, "R7 copies after reset", 64'(slow_regs), 0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule